// File: doc/BRIEF.md
# Multiplexed LCD Scan Controller

This block scans a passive LCD panel with four common electrodes and forty segment electrodes. It uses quarter duty and third bias. Software fills a write-only display latch one byte at a time. The latch holds one forty-bit row for each common. A slow timebase tick moves the scan from one common slot to the next. At 64 frames per second the tick runs at 256 Hz. Every second frame swaps the drive polarity, so the panel sees no net DC.

The block does not drive analog voltages. For every electrode it outputs a two-bit level code. An external bias network turns that code into Vss, one third of Vlcd, two thirds of Vlcd, or Vlcd. A display enable and a deep-sleep indication can both blank the panel. A mode pin can take the eight highest segment pins away from the display and hand them to a general output port.

The write port is a valid/ready stream. Ready is held high at all times, so the block never applies back-pressure. Every beat with valid high is taken in the cycle it is presented.

Top module: `lcd_scan`

## Requirements
- R1: After reset, common 0 is the active slot and the frame phase is even. The whole display latch reads as blank, so with the display on, COM0 shows 11, the other commons show 01, and every segment shows 10.
- R2: Each cycle with `tick` high moves the active common one step, in the order 0, 1, 2, 3 and back to 0. A cycle without `tick` holds the active common.
- R3: The frame phase inverts on the tick that wraps the scan from common 3 back to common 0. It changes at no other time.
- R4: With the display on, the active common shows 11 in the even phase and 00 in the odd phase. Inactive commons show 01 in the even phase and 10 in the odd phase. The codes mean 00 = Vss, 01 = 1/3 Vlcd, 10 = 2/3 Vlcd, 11 = Vlcd. Pin c occupies bits [2c+1:2c].
- R5: With the display on, a segment whose latch bit is set for the active common shows 00 in the even phase and 11 in the odd phase. A segment whose bit is clear shows 10 in the even phase and 01 in the odd phase. Segment s occupies bits [2s+1:2s].
- R6: A write to address `{c[1:0], k[2:0]}` with k from 0 to 4 stores the data byte into row c. Bit b of that byte controls segment 8k+b. The new value is visible on the outputs from the cycle after the write is accepted.
- R7: A write whose low three address bits are 5, 6 or 7 changes no latch content.
- R8: `wr_ready` is 1 in every cycle, and a beat counts as accepted whenever `wr_valid` is 1.
- R9: When `disp_en` is 0 or `deep_sleep` is 1, every common and segment code is 00. The scan position and the frame phase keep advancing regardless.
- R10: When `port_mode` is 1, segments 32 to 39 show 00 and `port_out` equals `port_data`. When `port_mode` is 0, `port_out` is 0 and those segments follow R5 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse that advances one common slot |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready, always 1 |
| wr_addr | input | 5 | Latch address: common in [4:3], byte in [2:0] |
| wr_data | input | 8 | Latch data byte |
| disp_en | input | 1 | Display enable |
| deep_sleep | input | 1 | Deepest sleep active; forces the display off |
| port_mode | input | 1 | Reassigns segments 32 to 39 to the general port |
| port_data | input | 8 | Value for the general output port |
| com_lvl | output | 8 | Level code for each common, 2 bits per pin |
| seg_lvl | output | 80 | Level code for each segment, 2 bits per pin |
| port_out | output | 8 | General output port pins |

## Verification
The bench builds the block with its default parameters: four commons, forty segments and an eight-pin port. The ticks arrive at irregular intervals, so the scan wraps through many frames and both polarities get checked against latch rows that change all the time. Random writes reach every row, every valid byte lane and the three unused byte slots of each row. The display enable, deep sleep and port mode are switched while scanning continues, so blanking and the port takeover are each seen in both phases and on every common.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    LV_VSS      = 2'b00,
    LV_THIRD    = 2'b01,
    LV_TWOTHIRD = 2'b10,
    LV_FULL     = 2'b11
  } lvl_t;
endpackage

// File: rtl/lcd_row_latch.sv
module lcd_row_latch #(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 40,
  parameter int CSEL_W  = 2,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [CSEL_W-1:0]  rd_sel,
  output logic [NUM_SEG-1:0] rd_row
);
  localparam int BYTES  = NUM_SEG / 8;
  localparam int BSEL_W = ADDR_W - CSEL_W;

  logic [NUM_COM*NUM_SEG-1:0] flat;
  logic [CSEL_W-1:0] wr_com;
  logic [BSEL_W-1:0] wr_byte;

  assign wr_com  = wr_addr[BSEL_W +: CSEL_W];
  assign wr_byte = wr_addr[BSEL_W-1:0];

  for (genvar r = 0; r < NUM_COM; r++) begin : g_row
    for (genvar k = 0; k < BYTES; k++) begin : g_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          byte_q <= '0;
        else if (wr_en && wr_com == CSEL_W'(r) && wr_byte == BSEL_W'(k))
          byte_q <= wr_data;
      end
      assign flat[r*NUM_SEG + 8*k +: 8] = byte_q;
    end
  end

  assign rd_row = flat[rd_sel*NUM_SEG +: NUM_SEG];

  // R7
  unused_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_byte) >= BYTES) |=> $stable(flat));
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq #(
  parameter int NUM_COM = 4,
  parameter int CSEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [CSEL_W-1:0] com_idx,
  output logic              phase
);
  localparam logic [CSEL_W-1:0] LAST = CSEL_W'(NUM_COM - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      com_idx <= '0;
      phase   <= 1'b0;
    end else if (tick) begin
      if (com_idx == LAST) begin
        com_idx <= '0;
        phase   <= ~phase;
      end else begin
        com_idx <= com_idx + 1'b1;
      end
    end
  end

  // R2
  hold_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(com_idx) && $stable(phase));
  // R2
  step_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && com_idx != LAST) |=> (com_idx == $past(com_idx) + 1'b1) && $stable(phase));
  // R3
  wrap_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && com_idx == LAST) |=> (com_idx == '0) && (phase != $past(phase)));
endmodule

// File: rtl/lcd_level_drive.sv
module lcd_level_drive
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 40,
  parameter int PORT_W  = 8,
  parameter int CSEL_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CSEL_W-1:0]    com_idx,
  input  logic                 phase,
  input  logic                 disp_on,
  input  logic                 port_mode,
  input  logic [NUM_SEG-1:0]   row,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl
);
  localparam int PORT_LO = NUM_SEG - PORT_W;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    lvl_t lv;
    always_comb begin
      if (!disp_on)
        lv = LV_VSS;
      else if (com_idx == CSEL_W'(c))
        lv = phase ? LV_VSS : LV_FULL;
      else
        lv = phase ? LV_TWOTHIRD : LV_THIRD;
    end
    assign com_lvl[2*c +: 2] = lv;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    lvl_t lv;
    logic taken;
    if (s >= PORT_LO) begin : g_shared
      assign taken = port_mode;
    end else begin : g_plain
      assign taken = 1'b0;
    end
    always_comb begin
      if (!disp_on || taken)
        lv = LV_VSS;
      else if (row[s])
        lv = phase ? LV_FULL : LV_VSS;
      else
        lv = phase ? LV_THIRD : LV_TWOTHIRD;
    end
    assign seg_lvl[2*s +: 2] = lv;
  end

  // R9
  blank_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (com_lvl == '0) && (seg_lvl == '0));
  // R10
  port_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_mode |-> (seg_lvl[2*NUM_SEG-1:2*PORT_LO] == '0));
endmodule

// File: rtl/lcd_scan.sv
module lcd_scan #(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 40,
  parameter int PORT_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [$clog2(NUM_COM)+2:0] wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   disp_en,
  input  logic                   deep_sleep,
  input  logic                   port_mode,
  input  logic [PORT_W-1:0]      port_data,
  output logic [2*NUM_COM-1:0]   com_lvl,
  output logic [2*NUM_SEG-1:0]   seg_lvl,
  output logic [PORT_W-1:0]      port_out
);
  localparam int CSEL_W = $clog2(NUM_COM);
  localparam int ADDR_W = CSEL_W + 3;

  logic [CSEL_W-1:0]  com_idx;
  logic               phase;
  logic [NUM_SEG-1:0] row;
  logic               disp_on;

  assign wr_ready = 1'b1;
  assign disp_on  = disp_en & ~deep_sleep;
  assign port_out = port_mode ? port_data : '0;

  lcd_scan_seq #(.NUM_COM(NUM_COM), .CSEL_W(CSEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .com_idx(com_idx), .phase(phase));

  lcd_row_latch #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .CSEL_W(CSEL_W),
                  .ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_valid & wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_sel(com_idx), .rd_row(row));

  lcd_level_drive #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .PORT_W(PORT_W),
                    .CSEL_W(CSEL_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .com_idx(com_idx), .phase(phase),
    .disp_on(disp_on), .port_mode(port_mode), .row(row),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl));

  // R8
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);
endmodule

// File: tb/sim_lcd_scan.sv
module sim_lcd_scan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_valid = 1'b0, disp_en = 1'b1, deep_sleep = 1'b0, port_mode = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0, port_data = '0;
  logic wr_ready;
  logic [7:0] com_lvl;
  logic [79:0] seg_lvl;
  logic [7:0] port_out;

  int total = 0, bad = 0;
  bit done = 0;
  bit lat [4][40];
  int comi = 0;
  int ph = 0;

  always #2 clk = ~clk;

  lcd_scan u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .disp_en(disp_en),
    .deep_sleep(deep_sleep), .port_mode(port_mode), .port_data(port_data),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .port_out(port_out));

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      comi = 0; ph = 0;
      foreach (lat[c, s]) lat[c][s] = 1'b0;
    end else begin
      if (wr_valid && wr_addr[2:0] < 5)
        for (int b = 0; b < 8; b++) lat[wr_addr[4:3]][8*wr_addr[2:0] + b] = wr_data[b];
      if (tick) begin
        comi = comi + 1;
        if (comi == 4) begin comi = 0; ph = 1 - ph; end
      end
    end
  end

  function automatic logic [7:0] exp_com();
    logic [7:0] v;
    bit on = disp_en && !deep_sleep;
    for (int c = 0; c < 4; c++)
      if (!on) v[2*c +: 2] = 2'b00;
      else if (c == comi) v[2*c +: 2] = ph ? 2'b00 : 2'b11;
      else v[2*c +: 2] = ph ? 2'b10 : 2'b01;
    return v;
  endfunction

  function automatic logic [79:0] exp_seg();
    logic [79:0] v;
    bit on = disp_en && !deep_sleep;
    for (int s = 0; s < 40; s++)
      if (!on || (port_mode && s >= 32)) v[2*s +: 2] = 2'b00;
      else if (lat[comi][s]) v[2*s +: 2] = ph ? 2'b11 : 2'b00;
      else v[2*s +: 2] = ph ? 2'b01 : 2'b10;
    return v;
  endfunction

  task automatic check(string tag, logic [79:0] got, logic [79:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s t=%0t got=%h exp=%h", tag, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check((disp_en && !deep_sleep) ? "R2 R3 R4 com" : "R9 com", 80'(com_lvl), 80'(exp_com()));
      check(port_mode ? "R5 R6 R7 R10 seg" : ((disp_en && !deep_sleep) ? "R5 R6 R7 seg" : "R9 seg"),
            seg_lvl, exp_seg());
      check("R10 port", 80'(port_out), 80'(port_mode ? port_data : 8'h00));
      check("R8 ready", 80'(wr_ready), 80'(1));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run(int n, int tick_pct, int wr_pct);
    for (int i = 0; i < n; i++) begin
      tick = ($urandom % 100) < tick_pct;
      wr_valid = ($urandom % 100) < wr_pct;
      wr_addr = 5'($urandom);
      wr_data = 8'($urandom);
      step();
    end
    tick = 0; wr_valid = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state with display on
    check("R1 com", 80'(com_lvl), 80'(8'h57));
    check("R1 seg", seg_lvl, {40{2'b10}});
    step();
    // R6: write row 1 byte 1 bit 0 -> SEG8, then move to common 1
    wr_valid = 1; wr_addr = 5'h09; wr_data = 8'h01; step();
    // R7: unused slot of row 1
    wr_addr = 5'h0D; wr_data = 8'hFF; step();
    wr_valid = 0; tick = 1; step(); tick = 0;
    @(negedge clk);
    check("R6 seg8", 80'(seg_lvl[17:16]), 80'(2'b00));
    check("R7 seg39", 80'(seg_lvl[79:78]), 80'(2'b10));
    step();
    run(800, 30, 50);
    disp_en = 0; run(300, 30, 40);
    disp_en = 1; deep_sleep = 1; run(300, 30, 40);
    deep_sleep = 0; port_mode = 1; port_data = 8'hA5; run(300, 30, 40);
    port_data = 8'h3C; disp_en = 0; run(200, 30, 40);
    disp_en = 1; port_mode = 0; run(1000, 40, 60);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1 got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule